// File: doc/BRIEF.md
# Bouncing LED Pattern Player

The block plays a fixed light pattern on five LEDs. The pattern fills from the low end until all five LEDs are lit. It then drains toward the high end, refills, and drains back to a single low LED. Seventeen five-bit entries are held in a small synchronous read-only table. The table is read through a registered port, so data appears one clock after its address.

A free-running dwell timer decides when the read address steps. The address visits every entry in order and returns to the first entry after the last one. The dwell timer's width is a parameter. A width of 22 bits, the default, gives a visible rate on a board clock. A small width shortens the dwell for simulation. A second parameter removes the timer so that the address steps on every clock.

Top module: `led_bounce_player`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next value of `leds` is 5'b00001. Reset also places the read address on entry 0 and clears the dwell timer.
- R2: The entries from index 0 to index 16 are 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000, 11000, 11100, 11110, 11111, 01111, 00111, 00011, 00001. Each string is written MSB first, and LED bit 0 is the rightmost character.
- R3: After the step taken from entry 16, the address returns to entry 0. The sequence then repeats without a gap.
- R4: `leds` shows the entry at the address that was current one clock earlier. This is a one-cycle read latency.
- R5: With `FAST_MODE`=0, the dwell timer counts up from 0. The address steps in the cycle where timer bit `DELAY_W-1` is 1, and the timer restarts at 0 in that same cycle. Each entry is therefore held for 2^(DELAY_W-1)+1 clocks.
- R6: With `FAST_MODE`=1, the address steps on every clock after reset. Each entry is then shown for exactly one clock.
- R7: Asserting reset in the middle of a run restarts the sequence from entry 0 with the full dwell.
- R8: `leds` does not change between steps. A change happens only in the clock that follows an address step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| leds | output | 5 | Current pattern entry driving the LEDs |

## Verification
A corrupted address or a corrupted table entry shows on `leds` one clock after it occurs. Each check compares the output with the entry computed from the elapsed cycle count. A dwell timer that is off by one shows as an early or late change within the first dwell period. After that, the whole sequence stays shifted, and every later check reports it. A wrap fault shows within one dwell period after entry 16. The fast variant covers every step edge in 17 clocks.

// File: rtl/led_bounce_pkg.sv
package led_bounce_pkg;

  localparam int LED_W       = 5;
  localparam int ENTRY_COUNT = 17;
  localparam int ADDR_W      = $clog2(ENTRY_COUNT);
  localparam int LAST_ADDR   = ENTRY_COUNT - 1;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic advance;   // move to the next entry this cycle
    logic restart;   // the move wraps back to entry 0
  } seq_strobe_t;

  // Fill/drain table, index order is the playback order
  function automatic logic [LED_W-1:0] patternAt(input logic [ADDR_W-1:0] idx);
    logic [LED_W-1:0] val;
    case (idx)
      5'd0:    val = 5'b00001;
      5'd1:    val = 5'b00011;
      5'd2:    val = 5'b00111;
      5'd3:    val = 5'b01111;
      5'd4:    val = 5'b11111;
      5'd5:    val = 5'b11110;
      5'd6:    val = 5'b11100;
      5'd7:    val = 5'b11000;
      5'd8:    val = 5'b10000;
      5'd9:    val = 5'b11000;
      5'd10:   val = 5'b11100;
      5'd11:   val = 5'b11110;
      5'd12:   val = 5'b11111;
      5'd13:   val = 5'b01111;
      5'd14:   val = 5'b00111;
      5'd15:   val = 5'b00011;
      5'd16:   val = 5'b00001;
      default: val = 5'b00001;
    endcase
    return val;
  endfunction

endpackage

// File: rtl/led_bounce_ctrl.sv
module led_bounce_ctrl
  import led_bounce_pkg::*;
#(
  parameter int DELAY_W   = 22,
  parameter bit FAST_MODE = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        atLast,
  output seq_strobe_t strobe
);

  logic tick;

  generate
    if (FAST_MODE) begin : g_fast
      // Simulation variant: no dwell, step every cycle
      assign tick = 1'b1;
    end else begin : g_timer
      logic [DELAY_W-1:0] dwellCnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          dwellCnt <= '0;
        end else if (dwellCnt[DELAY_W-1]) begin
          dwellCnt <= '0;
        end else begin
          dwellCnt <= dwellCnt + 1'b1;
        end
      end

      assign tick = dwellCnt[DELAY_W-1];
    end
  endgenerate

  always_comb begin
    strobe.advance = tick;
    strobe.restart = tick & atLast;
  end

endmodule

// File: rtl/led_bounce_datapath.sv
module led_bounce_datapath
  import led_bounce_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  seq_strobe_t       strobe,
  output logic              atLast,
  output logic [ADDR_W-1:0] addrQ,
  output logic [LED_W-1:0]  ledData
);

  logic [ADDR_W-1:0] addrNext;
  logic [LED_W-1:0]  readQ;

  always_comb begin
    if (strobe.restart) begin
      addrNext = '0;
    end else if (strobe.advance) begin
      addrNext = addrQ + 1'b1;
    end else begin
      addrNext = addrQ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
    end else begin
      addrQ <= addrNext;
    end
  end

  // Registered table read: one clock from address to data
  always_ff @(posedge clk) begin
    if (rst) begin
      readQ <= patternAt('0);
    end else begin
      readQ <= patternAt(addrQ);
    end
  end

  assign atLast  = (addrQ == ADDR_W'(LAST_ADDR));
  assign ledData = readQ;

endmodule

// File: rtl/led_bounce_player.sv
module led_bounce_player
  import led_bounce_pkg::*;
#(
  parameter int DELAY_W   = 22,
  parameter bit FAST_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  output logic [LED_W-1:0] leds
);

  seq_strobe_t       strobe;
  logic              atLast;
  logic [ADDR_W-1:0] addrQ;
  logic              stepNow;

  led_bounce_ctrl #(
    .DELAY_W   (DELAY_W),
    .FAST_MODE (FAST_MODE)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .atLast (atLast),
    .strobe (strobe)
  );

  led_bounce_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .atLast  (atLast),
    .addrQ   (addrQ),
    .ledData (leds)
  );

  assign stepNow = strobe.advance;

endmodule

// File: rtl/led_bounce_player_chk.sv
module led_bounce_player_chk
  import led_bounce_pkg::*;
#(
  parameter int DELAY_W   = 22,
  parameter bit FAST_MODE = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic [LED_W-1:0]  leds,
  input logic [ADDR_W-1:0] addrQ,
  input logic              stepNow
);

  localparam int HOLD_LAST = FAST_MODE ? 0 : (1 << (DELAY_W - 1));

  // Cycles spent on the current entry, counted independently of the timer
  logic [DELAY_W:0] holdCnt;
  always_ff @(posedge clk) begin
    if (rst || stepNow) begin
      holdCnt <= '0;
    end else begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  p_reset_leds_r1: assert property (@(posedge clk)
    rst |=> (leds == 5'b00001));

  p_reset_addr_r1: assert property (@(posedge clk)
    rst |=> (addrQ == '0));

  p_addr_range_r3: assert property (@(posedge clk) disable iff (rst)
    addrQ <= ADDR_W'(LAST_ADDR));

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (stepNow && addrQ == ADDR_W'(LAST_ADDR)) |=> (addrQ == '0));

  p_step_inc_r5: assert property (@(posedge clk) disable iff (rst)
    (stepNow && addrQ != ADDR_W'(LAST_ADDR)) |=> (addrQ == $past(addrQ) + 1'b1));

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !stepNow |=> $stable(addrQ));

  p_leds_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(stepNow)) |=> $stable(leds));

  p_dwell_len_r5: assert property (@(posedge clk) disable iff (rst)
    stepNow |-> (holdCnt == (DELAY_W+1)'(HOLD_LAST)));

  generate
    if (FAST_MODE) begin : g_fast_chk
      p_every_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        stepNow);
    end
  endgenerate

endmodule

bind led_bounce_player led_bounce_player_chk #(
  .DELAY_W   (DELAY_W),
  .FAST_MODE (FAST_MODE)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .leds    (leds),
  .addrQ   (addrQ),
  .stepNow (stepNow)
);

// File: tb/led_bounce_player_tb.sv
`timescale 1ns/1ps
module led_bounce_player_tb;

  localparam int SLOW_W  = 4;
  localparam int DWELL   = (1 << (SLOW_W - 1)) + 1;   // 9 clocks per entry
  localparam int ENTRIES = 17;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] ledsSlow;
  logic [4:0] ledsFast;

  int testsRun  = 0;
  int testsFail = 0;
  bit finished  = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  led_bounce_player #(.DELAY_W(SLOW_W), .FAST_MODE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .leds(ledsSlow)
  );

  led_bounce_player #(.DELAY_W(SLOW_W), .FAST_MODE(1'b1)) u_dut_fast (
    .clk(clk), .rst(rst), .leds(ledsFast)
  );

  // Expected entry, built from the fill/drain shape
  function automatic logic [4:0] expEntry(input int idx);
    int j;
    j = (idx > 8) ? (16 - idx) : idx;
    if (j <= 4) return 5'((1 << (j + 1)) - 1);
    return 5'((5'b11111 << (j - 4)) & 5'h1f);
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s: leds actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  endtask

  // Run n clocks after reset release, checking both players every cycle
  task automatic run_and_check(input int cycles);
    for (int n = 1; n <= cycles; n++) begin
      int slowIdx;
      int fastIdx;
      @(posedge clk);
      @(negedge clk);
      slowIdx = ((n - 1) / DWELL) % ENTRIES;
      fastIdx = (n - 1) % ENTRIES;
      if ((n - 1) / DWELL >= ENTRIES && slowIdx == 0)
        check("R3 slow wrap", ledsSlow, expEntry(slowIdx));
      else if ((n - 1) % DWELL == 0)
        check("R4 slow latency", ledsSlow, expEntry(slowIdx));
      else
        check("R5/R8 slow dwell", ledsSlow, expEntry(slowIdx));
      if (n > ENTRIES && fastIdx == 0)
        check("R3 fast wrap", ledsFast, expEntry(fastIdx));
      else
        check("R6 fast step", ledsFast, expEntry(fastIdx));
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset slow", ledsSlow, 5'b00001);
    check("R1 reset fast", ledsFast, 5'b00001);
    // R2: table order checked against the computed shape over two full passes
    rst = 1'b0;
    run_and_check(2 * ENTRIES * DWELL + 5);
    // R7: reset in mid-run, then restart from entry 0
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R7 reset slow", ledsSlow, 5'b00001);
    check("R7 reset fast", ledsFast, 5'b00001);
    rst = 1'b0;
    run_and_check(4 * DWELL);
    finish_run();
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    testsRun++;
    testsFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule